// File: doc/BRIEF.md
# Base-Integer Instruction Decoder

This block turns one 32-bit base-integer RISC-V instruction word into the control bundle a simple datapath needs. The bundle covers the register-file addresses and write enable, and the select for what is written back. It holds the ALU operand selects, a 3-bit ALU operation with signed, negate-second-operand and carry-in modifiers, and a 32-bit immediate extended from its top bit. It also carries the data-memory write enable, access size and load sign-extension flag, the PC source select, a conditional-branch flag, a zero-flag inversion flag and a breakpoint flag.

Subtraction and every compare are expressed as "negate operand B, add one" on the adder or less-than unit. There is no separate subtract code. A conditional branch does not get its own condition signal: the datapath takes it when (zero flag XOR inversion flag) is 1. Any encoding the block does not recognise decodes to a no-op.

The decode logic is combinational, and its results are captured in output registers. Every output therefore follows the instruction presented one rising clock edge earlier. A synchronous active-high reset clears every output register.

Top module: `instr_decode_unit`

## Requirements
- R1: All outputs are registered. The values seen after a rising edge are the decode of `instr_i` sampled at that edge. With `rst` high at an edge, every output becomes 0, which is the no-op bundle.
- R2: `rs1_o`, `rs2_o` and `rd_o` always carry instruction bits [19:15], [24:20] and [11:7], whatever the opcode.
- R3: The immediate is formed as follows. I-format uses bits [31:20]. S-format is {[31:25],[11:7]}. B-format is {[31],[7],[30:25],[11:8],0}. J-format is {[31],[19:12],[20],[30:21],0}. U-format is {[31:12],12'h000}. Each is extended from its top bit. Register-register ops and no-ops give 0.
- R4: Opcode 0010011 (immediate) and 0110011 (register) write rd from the ALU. Operand A selects rs1. B selects the immediate for the immediate opcode (`alu_b_sel_o`=1) and rs2 for the register opcode (0). funct3 maps to `alu_op_o` as follows: 000→0 add, 001→1 shift left, 010/011→2 less-than, 100→4 xor, 101→5 shift right, 110→6 or, 111→7 and.
- R5: Register funct3 000 with funct7 0100000 is subtract and sets negate and add-one. Less-than (funct3 010/011) sets negate and add-one, and sets signed only for 010. Shift right sets signed when funct7 is 0100000.
- R6: Opcode 0000011 loads. It writes rd from memory data (`rd_sel_o`=1) and forms the address as rs1+immediate. `mem_size_o` is funct3[1:0] (0 byte, 1 half, 2 word). `load_sext_o` is 1 for funct3 000/001/010 and 0 for 100/101.
- R7: Opcode 0100011 stores. It sets `mem_we_o` with the same size code, writes no register and adds rs1+immediate. No other opcode sets `mem_we_o`.
- R8: Opcode 1100011 is a branch. It sets `branch_o`, selects PC+immediate (`pc_sel_o`=1) and negates rs2 with add-one. It writes nothing. funct3 000/001 use add (op 0). funct3 100/101/110/111 use less-than (op 2), signed only for 100/101. `zero_inv_o` is 1 for 001, 100 and 110.
- R9: Opcode 1101111 writes PC+4 to rd (`rd_sel_o`=2) and selects `pc_sel_o`=1. Opcode 1100111 with funct3 000 writes PC+4 and selects the ALU sum rs1+immediate (`pc_sel_o`=2).
- R10: Opcode 0010111 adds PC (`alu_a_sel_o`=1) to the U-immediate. Opcode 0110111 adds zero (`alu_a_sel_o`=2) to it. Both write rd.
- R11: The exact word 32'h00100073 sets `ebreak_o` with all other controls at no-op. Any other word with opcode 1110011 is a plain no-op.
- R12: Unknown opcodes and unsupported funct fields decode to the no-op bundle. This covers funct7 outside 0000000/0100000, and 0100000 on register funct3 other than 000/101. It covers immediate shifts with a bad funct7, load funct3 011/110/111, store funct3 above 010, branch funct3 010/011 and jump-register funct3 not 000. The no-op bundle is all zero except the three register addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word to decode |
| rs1_o | output | 5 | First source register address |
| rs2_o | output | 5 | Second source register address |
| rd_o | output | 5 | Destination register address |
| rd_we_o | output | 1 | Destination register write enable |
| rd_sel_o | output | 2 | Write-back source: 0 ALU, 1 load data, 2 PC+4 |
| alu_a_sel_o | output | 2 | ALU operand A: 0 rs1, 1 PC, 2 zero |
| alu_b_sel_o | output | 1 | ALU operand B: 0 rs2, 1 immediate |
| alu_op_o | output | 3 | ALU operation code |
| alu_signed_o | output | 1 | Signed compare / arithmetic shift |
| alu_neg_b_o | output | 1 | Invert operand B |
| alu_inc_o | output | 1 | Carry-in of one |
| imm_o | output | 32 | Extended immediate |
| mem_we_o | output | 1 | Data-memory write enable |
| mem_size_o | output | 2 | Access size: 0 byte, 1 half, 2 word |
| load_sext_o | output | 1 | Sign-extend load data |
| pc_sel_o | output | 2 | Next PC: 0 PC+4, 1 PC+immediate, 2 ALU result |
| branch_o | output | 1 | Conditional branch |
| zero_inv_o | output | 1 | Take branch when zero flag is clear |
| ebreak_o | output | 1 | Breakpoint instruction |

## Verification
Every output is due exactly one rising edge after the instruction word is applied, and the same holds for the cleared bundle under reset. The driver applies each word at a falling edge and queues the expected bundle for it. The monitor pops one item 1 ns after each following rising edge, so each comparison lands in the single cycle where that instruction's decode is on the ports. The reset checks sample the ports after an edge taken with `rst` high, with a non-zero instruction present, to show that the instruction had no effect.

// File: rtl/idu_pkg.sv
package idu_pkg;

  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_SYSTEM = 7'b1110011;
  localparam logic [31:0] WORD_BREAK = 32'h0010_0073;

  typedef enum logic [1:0] {PC_SEQ = 2'd0, PC_REL = 2'd1, PC_ALU = 2'd2} pc_sel_e;
  typedef enum logic [1:0] {RD_ALU = 2'd0, RD_MEM = 2'd1, RD_LINK = 2'd2} rd_sel_e;
  typedef enum logic [1:0] {A_RS1 = 2'd0, A_PC = 2'd1, A_ZERO = 2'd2} a_sel_e;
  typedef enum logic [0:0] {B_RS2 = 1'b0, B_IMM = 1'b1} b_sel_e;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_SHL = 3'd1, OP_LT = 3'd2, OP_XOR = 3'd4,
    OP_SHR = 3'd5, OP_OR = 3'd6, OP_AND = 3'd7
  } alu_op_e;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} mem_size_e;
  typedef enum logic [2:0] {
    IMM_NONE = 3'd0, IMM_I = 3'd1, IMM_S = 3'd2, IMM_B = 3'd3, IMM_J = 3'd4, IMM_U = 3'd5
  } imm_fmt_e;

  typedef struct packed {
    logic      rd_we;
    rd_sel_e   rd_sel;
    a_sel_e    a_sel;
    b_sel_e    b_sel;
    alu_op_e   op;
    logic      sgn;
    logic      neg;
    logic      inc;
    logic      mem_we;
    mem_size_e size;
    logic      sext;
    pc_sel_e   pc_sel;
    logic      branch;
    logic      zinv;
    logic      ebreak;
  } ctrl_t;

endpackage

// File: rtl/idu_imm.sv
module idu_imm
  import idu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int ILEN = 32
) (
  input  logic [ILEN-1:7] instr_i,
  input  imm_fmt_e        fmt_i,
  output logic [XLEN-1:0] imm_o
);
  localparam int TOP = ILEN - 1;

  logic [31:0] raw;

  always_comb begin
    unique case (fmt_i)
      IMM_I:   raw = {{20{instr_i[TOP]}}, instr_i[31:20]};
      IMM_S:   raw = {{20{instr_i[TOP]}}, instr_i[31:25], instr_i[11:7]};
      IMM_B:   raw = {{19{instr_i[TOP]}}, instr_i[31], instr_i[7], instr_i[30:25],
                      instr_i[11:8], 1'b0};
      IMM_J:   raw = {{11{instr_i[TOP]}}, instr_i[31], instr_i[19:12], instr_i[20],
                      instr_i[30:21], 1'b0};
      IMM_U:   raw = {instr_i[31:12], 12'h000};
      default: raw = 32'h0;
    endcase
  end

  assign imm_o = XLEN'($signed(raw));
endmodule

// File: rtl/idu_ctrl.sv
module idu_ctrl
  import idu_pkg::*;
#(
  parameter int ILEN = 32
) (
  input  logic [ILEN-1:0] instr_i,
  output ctrl_t           ctrl_o,
  output imm_fmt_e        fmt_o
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;
  logic       alt;
  logic       f7_ok;
  logic       bad;
  ctrl_t      c;
  imm_fmt_e   fmt;

  assign opc   = instr_i[6:0];
  assign f3    = instr_i[14:12];
  assign f7    = instr_i[31:25];
  assign alt   = (f7 == 7'b0100000);
  assign f7_ok = (f7 == 7'b0000000) || alt;

  // shared ALU field mapping for the register and immediate opcodes
  function automatic ctrl_t alu_map(input ctrl_t base, input logic [2:0] fn,
                                    input logic is_sub, input logic is_alt);
    ctrl_t r;
    r = base;
    case (fn)
      3'b000: begin r.op = OP_ADD; r.neg = is_sub; r.inc = is_sub; end
      3'b001: r.op = OP_SHL;
      3'b010: begin r.op = OP_LT; r.sgn = 1'b1; r.neg = 1'b1; r.inc = 1'b1; end
      3'b011: begin r.op = OP_LT; r.neg = 1'b1; r.inc = 1'b1; end
      3'b100: r.op = OP_XOR;
      3'b101: begin r.op = OP_SHR; r.sgn = is_alt; end
      3'b110: r.op = OP_OR;
      default: r.op = OP_AND;
    endcase
    return r;
  endfunction

  always_comb begin
    c   = '0;
    fmt = IMM_NONE;
    bad = 1'b0;
    case (opc)
      OPC_OP: begin
        c.rd_we = 1'b1;
        c       = alu_map(c, f3, alt, alt);
        bad     = !f7_ok || (alt && (f3 != 3'b000) && (f3 != 3'b101));
      end
      OPC_OPIMM: begin
        c.rd_we = 1'b1;
        c.b_sel = B_IMM;
        fmt     = IMM_I;
        c       = alu_map(c, f3, 1'b0, alt);
        bad     = ((f3 == 3'b001) && (f7 != 7'b0)) || ((f3 == 3'b101) && !f7_ok);
      end
      OPC_LOAD: begin
        c.rd_we  = 1'b1;
        c.rd_sel = RD_MEM;
        c.b_sel  = B_IMM;
        c.size   = mem_size_e'(f3[1:0]);
        c.sext   = !f3[2];
        fmt      = IMM_I;
        bad      = (f3[1:0] == 2'b11) || (f3[2] && f3[1]);
      end
      OPC_STORE: begin
        c.mem_we = 1'b1;
        c.b_sel  = B_IMM;
        c.size   = mem_size_e'(f3[1:0]);
        fmt      = IMM_S;
        bad      = f3[2] || (f3[1:0] == 2'b11);
      end
      OPC_BRANCH: begin
        c.branch = 1'b1;
        c.pc_sel = PC_REL;
        c.op     = f3[2] ? OP_LT : OP_ADD;
        c.sgn    = f3[2] && !f3[1];
        c.neg    = 1'b1;
        c.inc    = 1'b1;
        c.zinv   = f3[0] ^ f3[2];
        fmt      = IMM_B;
        bad      = (f3[2:1] == 2'b01);
      end
      OPC_JAL: begin
        c.rd_we  = 1'b1;
        c.rd_sel = RD_LINK;
        c.a_sel  = A_PC;
        c.b_sel  = B_IMM;
        c.pc_sel = PC_REL;
        fmt      = IMM_J;
      end
      OPC_JALR: begin
        c.rd_we  = 1'b1;
        c.rd_sel = RD_LINK;
        c.b_sel  = B_IMM;
        c.pc_sel = PC_ALU;
        fmt      = IMM_I;
        bad      = (f3 != 3'b000);
      end
      OPC_AUIPC: begin
        c.rd_we = 1'b1;
        c.a_sel = A_PC;
        c.b_sel = B_IMM;
        fmt     = IMM_U;
      end
      OPC_LUI: begin
        c.rd_we = 1'b1;
        c.a_sel = A_ZERO;
        c.b_sel = B_IMM;
        fmt     = IMM_U;
      end
      OPC_SYSTEM: begin
        c.ebreak = (instr_i == WORD_BREAK);
        bad      = (instr_i != WORD_BREAK);
      end
      default: bad = 1'b1;
    endcase
    if (bad) begin
      c   = '0;
      fmt = IMM_NONE;
    end
  end

  assign ctrl_o = c;
  assign fmt_o  = fmt;
endmodule

// File: rtl/instr_decode_unit.sv
module instr_decode_unit
  import idu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int ILEN = 32,
  parameter int RAW  = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [31:0]     instr_i,
  output logic [4:0]      rs1_o,
  output logic [4:0]      rs2_o,
  output logic [4:0]      rd_o,
  output logic            rd_we_o,
  output logic [1:0]      rd_sel_o,
  output logic [1:0]      alu_a_sel_o,
  output logic            alu_b_sel_o,
  output logic [2:0]      alu_op_o,
  output logic            alu_signed_o,
  output logic            alu_neg_b_o,
  output logic            alu_inc_o,
  output logic [31:0]     imm_o,
  output logic            mem_we_o,
  output logic [1:0]      mem_size_o,
  output logic            load_sext_o,
  output logic [1:0]      pc_sel_o,
  output logic            branch_o,
  output logic            zero_inv_o,
  output logic            ebreak_o
);
  localparam int RS1_LO = 15;
  localparam int RS2_LO = 20;
  localparam int RD_LO  = 7;

  ctrl_t           ctrl_d, ctrl_q;
  imm_fmt_e        fmt;
  logic [XLEN-1:0] imm_d, imm_q;
  logic [RAW-1:0]  rs1_q, rs2_q, rd_q;

  idu_ctrl #(.ILEN(ILEN)) u_ctrl (
    .instr_i (instr_i),
    .ctrl_o  (ctrl_d),
    .fmt_o   (fmt)
  );

  idu_imm #(.XLEN(XLEN), .ILEN(ILEN)) u_imm (
    .instr_i (instr_i[ILEN-1:7]),
    .fmt_i   (fmt),
    .imm_o   (imm_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      imm_q  <= '0;
      rs1_q  <= '0;
      rs2_q  <= '0;
      rd_q   <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      imm_q  <= imm_d;
      rs1_q  <= instr_i[RS1_LO +: RAW];
      rs2_q  <= instr_i[RS2_LO +: RAW];
      rd_q   <= instr_i[RD_LO +: RAW];
    end
  end

  assign rs1_o        = rs1_q;
  assign rs2_o        = rs2_q;
  assign rd_o         = rd_q;
  assign rd_we_o      = ctrl_q.rd_we;
  assign rd_sel_o     = ctrl_q.rd_sel;
  assign alu_a_sel_o  = ctrl_q.a_sel;
  assign alu_b_sel_o  = ctrl_q.b_sel;
  assign alu_op_o     = ctrl_q.op;
  assign alu_signed_o = ctrl_q.sgn;
  assign alu_neg_b_o  = ctrl_q.neg;
  assign alu_inc_o    = ctrl_q.inc;
  assign imm_o        = imm_q[31:0];
  assign mem_we_o     = ctrl_q.mem_we;
  assign mem_size_o   = ctrl_q.size;
  assign load_sext_o  = ctrl_q.sext;
  assign pc_sel_o     = ctrl_q.pc_sel;
  assign branch_o     = ctrl_q.branch;
  assign zero_inv_o   = ctrl_q.zinv;
  assign ebreak_o     = ctrl_q.ebreak;

  // ---------------- assertions ----------------
  logic live_q;
  logic known_opc;
  always_ff @(posedge clk) begin
    if (rst) live_q <= 1'b0;
    else     live_q <= 1'b1;
  end
  assign known_opc = instr_i[6:0] inside {OPC_LOAD, OPC_OPIMM, OPC_AUIPC, OPC_STORE,
                                          OPC_OP, OPC_LUI, OPC_BRANCH, OPC_JALR,
                                          OPC_JAL, OPC_SYSTEM};

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    !live_q |-> (!rd_we_o && !mem_we_o && pc_sel_o == 2'd0 && imm_o == 32'h0));

  assert_fields_pass_R2: assert property (@(posedge clk) disable iff (rst)
    live_q |-> (rs1_o == $past(instr_i[19:15]) && rd_o == $past(instr_i[11:7])));

  assert_pcrel_even_R3: assert property (@(posedge clk) disable iff (rst)
    (pc_sel_o == 2'd1) |-> (imm_o[0] == 1'b0));

  assert_store_only_R7: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> (!rd_we_o && pc_sel_o == 2'd0 && !branch_o));

  assert_branch_shape_R8: assert property (@(posedge clk) disable iff (rst)
    branch_o |-> (pc_sel_o == 2'd1 && !rd_we_o && alu_neg_b_o && alu_inc_o));

  assert_upper_low_R10: assert property (@(posedge clk) disable iff (rst)
    (alu_a_sel_o == 2'd2) |-> (imm_o[11:0] == 12'h000 && rd_we_o));

  assert_break_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    ebreak_o |-> (!rd_we_o && !mem_we_o && pc_sel_o == 2'd0 && !branch_o));

  assert_unknown_nop_R12: assert property (@(posedge clk) disable iff (rst)
    (live_q && !$past(known_opc)) |-> (!rd_we_o && !mem_we_o && pc_sel_o == 2'd0
                                        && !branch_o && !ebreak_o));
endmodule

// File: tb/test_instr_decode_unit.sv
`timescale 1ns/100ps
module test_instr_decode_unit;
  typedef struct packed {
    logic [4:0] rs1, rs2, rd;
    logic       we;
    logic [1:0] rsel, asel;
    logic       bsel;
    logic [2:0] op;
    logic       sg, ng, inc;
    logic [31:0] imm;
    logic       mwe;
    logic [1:0] sz;
    logic       sx;
    logic [1:0] pc;
    logic       br, inv, eb;
  } exp_t;

  localparam logic [6:0] LD = 7'b0000011, OI = 7'b0010011, AU = 7'b0010111,
                         ST = 7'b0100011, RR = 7'b0110011, LU = 7'b0110111,
                         BR = 7'b1100011, JR = 7'b1100111, JL = 7'b1101111;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] instr_i = 32'h0;
  logic [4:0] rs1_o, rs2_o, rd_o;
  logic rd_we_o, alu_b_sel_o, alu_signed_o, alu_neg_b_o, alu_inc_o;
  logic [1:0] rd_sel_o, alu_a_sel_o, mem_size_o, pc_sel_o;
  logic [2:0] alu_op_o;
  logic [31:0] imm_o;
  logic mem_we_o, load_sext_o, branch_o, zero_inv_o, ebreak_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  exp_t  q_exp[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  instr_decode_unit i_instr_decode_unit (
    .clk(clk), .rst(rst), .instr_i(instr_i),
    .rs1_o(rs1_o), .rs2_o(rs2_o), .rd_o(rd_o), .rd_we_o(rd_we_o), .rd_sel_o(rd_sel_o),
    .alu_a_sel_o(alu_a_sel_o), .alu_b_sel_o(alu_b_sel_o), .alu_op_o(alu_op_o),
    .alu_signed_o(alu_signed_o), .alu_neg_b_o(alu_neg_b_o), .alu_inc_o(alu_inc_o),
    .imm_o(imm_o), .mem_we_o(mem_we_o), .mem_size_o(mem_size_o),
    .load_sext_o(load_sext_o), .pc_sel_o(pc_sel_o), .branch_o(branch_o),
    .zero_inv_o(zero_inv_o), .ebreak_o(ebreak_o)
  );

  function automatic exp_t actual();
    return {rs1_o, rs2_o, rd_o, rd_we_o, rd_sel_o, alu_a_sel_o, alu_b_sel_o, alu_op_o,
            alu_signed_o, alu_neg_b_o, alu_inc_o, imm_o, mem_we_o, mem_size_o,
            load_sext_o, pc_sel_o, branch_o, zero_inv_o, ebreak_o};
  endfunction

  function automatic exp_t mk(input logic [31:0] ins, input logic we, input logic [1:0] rsel,
      input logic [1:0] asel, input logic bsel, input logic [2:0] op, input logic sg,
      input logic ng, input logic inc, input logic [31:0] imm, input logic mwe,
      input logic [1:0] sz, input logic sx, input logic [1:0] pc, input logic br,
      input logic inv, input logic eb);
    exp_t e;
    e.rs1 = ins[19:15]; e.rs2 = ins[24:20]; e.rd = ins[11:7];
    e.we = we; e.rsel = rsel; e.asel = asel; e.bsel = bsel; e.op = op;
    e.sg = sg; e.ng = ng; e.inc = inc; e.imm = imm; e.mwe = mwe; e.sz = sz;
    e.sx = sx; e.pc = pc; e.br = br; e.inv = inv; e.eb = eb;
    return e;
  endfunction

  function automatic exp_t nopx(input logic [31:0] ins);
    return mk(ins, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0, 0, 0, 0, 0, 0, 0, 0);
  endfunction

  task automatic check(input string tag, input exp_t got, input exp_t exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic send(input logic [31:0] ins, input exp_t e, input string tag);
    @(negedge clk);
    instr_i = ins;
    q_exp.push_back(e);
    q_tag.push_back(tag);
  endtask

  // monitor: each item is due one rising edge after it was driven
  always @(posedge clk) begin
    #1;
    if (!rst && q_exp.size() > 0) begin
      exp_t e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      check(t, actual(), e);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] w;
    // R1: reset state with a live instruction present
    instr_i = {12'h111, 5'd2, 3'b000, 5'd1, OI};
    repeat (3) @(posedge clk);
    #1 check("R1 reset state", actual(), '0);
    @(negedge clk) rst = 1'b0;

    // R4 R3 R2 immediate ALU forms
    w = {12'h111, 5'd2, 3'b000, 5'd1, OI};
    send(w, mk(w,1,0,0,1,0,0,0,0,32'h111,0,0,0,0,0,0,0), "R4 R2 addi");
    w = {12'hFFF, 5'd2, 3'b000, 5'd1, OI};
    send(w, mk(w,1,0,0,1,0,0,0,0,32'hFFFFFFFF,0,0,0,0,0,0,0), "R3 addi negative");
    w = {12'hFFB, 5'd2, 3'b010, 5'd1, OI};
    send(w, mk(w,1,0,0,1,2,1,1,1,32'hFFFFFFFB,0,0,0,0,0,0,0), "R5 slti");
    w = {12'h0F0, 5'd7, 3'b111, 5'd9, OI};
    send(w, mk(w,1,0,0,1,7,0,0,0,32'h0F0,0,0,0,0,0,0,0), "R4 andi");
    w = {7'b0, 5'd4, 5'd2, 3'b001, 5'd1, OI};
    send(w, mk(w,1,0,0,1,1,0,0,0,32'h4,0,0,0,0,0,0,0), "R4 slli");
    w = {7'b0100000, 5'd3, 5'd2, 3'b101, 5'd1, OI};
    send(w, mk(w,1,0,0,1,5,1,0,0,32'h403,0,0,0,0,0,0,0), "R5 srai");
    w = {7'b0100000, 5'd4, 5'd2, 3'b001, 5'd1, OI};
    send(w, nopx(w), "R12 slli bad funct7");

    // register-register
    w = {7'b0, 5'd2, 5'd3, 3'b000, 5'd1, RR};
    send(w, mk(w,1,0,0,0,0,0,0,0,32'h0,0,0,0,0,0,0,0), "R4 add");
    w = {7'b0100000, 5'd3, 5'd2, 3'b000, 5'd1, RR};
    send(w, mk(w,1,0,0,0,0,0,1,1,32'h0,0,0,0,0,0,0,0), "R5 sub");
    w = {7'b0, 5'd2, 5'd3, 3'b010, 5'd1, RR};
    send(w, mk(w,1,0,0,0,2,1,1,1,32'h0,0,0,0,0,0,0,0), "R5 slt");
    w = {7'b0, 5'd6, 5'd5, 3'b011, 5'd4, RR};
    send(w, mk(w,1,0,0,0,2,0,1,1,32'h0,0,0,0,0,0,0,0), "R5 sltu");
    w = {7'b0, 5'd2, 5'd3, 3'b110, 5'd1, RR};
    send(w, mk(w,1,0,0,0,6,0,0,0,32'h0,0,0,0,0,0,0,0), "R4 or");
    w = {7'b0100000, 5'd2, 5'd3, 3'b101, 5'd1, RR};
    send(w, mk(w,1,0,0,0,5,1,0,0,32'h0,0,0,0,0,0,0,0), "R5 sra");
    w = {7'b0, 5'd2, 5'd3, 3'b101, 5'd1, RR};
    send(w, mk(w,1,0,0,0,5,0,0,0,32'h0,0,0,0,0,0,0,0), "R5 srl");
    w = {7'b0100000, 5'd2, 5'd3, 3'b100, 5'd1, RR};
    send(w, nopx(w), "R12 xor alt funct7");
    w = {7'b0000001, 5'd2, 5'd3, 3'b000, 5'd1, RR};
    send(w, nopx(w), "R12 funct7 0000001");

    // loads
    w = {12'h111, 5'd2, 3'b000, 5'd1, LD};
    send(w, mk(w,1,1,0,1,0,0,0,0,32'h111,0,0,1,0,0,0,0), "R6 load byte");
    w = {12'h111, 5'd2, 3'b010, 5'd1, LD};
    send(w, mk(w,1,1,0,1,0,0,0,0,32'h111,0,2,1,0,0,0,0), "R6 load word");
    w = {12'h800, 5'd2, 3'b101, 5'd1, LD};
    send(w, mk(w,1,1,0,1,0,0,0,0,32'hFFFFF800,0,1,0,0,0,0,0), "R6 load half unsigned");
    w = {12'h004, 5'd2, 3'b100, 5'd1, LD};
    send(w, mk(w,1,1,0,1,0,0,0,0,32'h4,0,0,0,0,0,0,0), "R6 load byte unsigned");
    w = {12'h004, 5'd2, 3'b011, 5'd1, LD};
    send(w, nopx(w), "R12 load funct3 011");

    // stores
    w = {7'b0000001, 5'd1, 5'd2, 3'b000, 5'b00001, ST};
    send(w, mk(w,0,0,0,1,0,0,0,0,32'h21,1,0,0,0,0,0,0), "R7 store byte");
    w = {7'b1111111, 5'd1, 5'd2, 3'b010, 5'b11000, ST};
    send(w, mk(w,0,0,0,1,0,0,0,0,32'hFFFFFFF8,1,2,0,0,0,0,0), "R7 R3 store word neg");
    w = {7'b0000001, 5'd1, 5'd2, 3'b100, 5'b00001, ST};
    send(w, nopx(w), "R12 store funct3 100");

    // branches
    w = {7'b1100000, 5'd1, 5'd2, 3'b000, 5'b00011, BR};
    send(w, mk(w,0,0,0,0,0,0,1,1,32'hFFFFFC02,0,0,0,1,1,0,0), "R8 R3 beq");
    w = {7'b0000001, 5'd1, 5'd2, 3'b001, 5'b00001, BR};
    send(w, mk(w,0,0,0,0,0,0,1,1,32'h820,0,0,0,1,1,1,0), "R8 bne");
    w = {7'b0000001, 5'd1, 5'd2, 3'b101, 5'b00001, BR};
    send(w, mk(w,0,0,0,0,2,1,1,1,32'h820,0,0,0,1,1,0,0), "R8 bge");
    w = {7'b0000001, 5'd1, 5'd2, 3'b100, 5'b00001, BR};
    send(w, mk(w,0,0,0,0,2,1,1,1,32'h820,0,0,0,1,1,1,0), "R8 blt");
    w = {7'b0000001, 5'd1, 5'd2, 3'b110, 5'b00001, BR};
    send(w, mk(w,0,0,0,0,2,0,1,1,32'h820,0,0,0,1,1,1,0), "R8 bltu");
    w = {7'b0000001, 5'd1, 5'd2, 3'b111, 5'b00001, BR};
    send(w, mk(w,0,0,0,0,2,0,1,1,32'h820,0,0,0,1,1,0,0), "R8 bgeu");
    w = {7'b0000001, 5'd1, 5'd2, 3'b010, 5'b00001, BR};
    send(w, nopx(w), "R12 branch funct3 010");

    // jumps
    w = {20'b10000000001100000001, 5'd1, JL};
    send(w, mk(w,1,2,1,1,0,0,0,0,32'hFFF01802,0,0,0,1,0,0,0), "R9 R3 jal");
    w = {12'h001, 5'd1, 3'b000, 5'd1, JR};
    send(w, mk(w,1,2,0,1,0,0,0,0,32'h1,0,0,0,2,0,0,0), "R9 jalr");
    w = {12'h001, 5'd1, 3'b001, 5'd1, JR};
    send(w, nopx(w), "R12 jalr funct3 001");

    // upper immediates
    w = {20'hA000A, 5'd1, AU};
    send(w, mk(w,1,0,1,1,0,0,0,0,32'hA000A000,0,0,0,0,0,0,0), "R10 auipc");
    w = {20'hA000A, 5'd1, LU};
    send(w, mk(w,1,0,2,1,0,0,0,0,32'hA000A000,0,0,0,0,0,0,0), "R10 lui");

    // system and unknown
    w = 32'h0010_0073;
    send(w, mk(w,0,0,0,0,0,0,0,0,32'h0,0,0,0,0,0,0,1), "R11 ebreak");
    w = 32'h0000_0073;
    send(w, nopx(w), "R11 ecall no-op");
    w = 32'hFFFF_FF7F;
    send(w, nopx(w), "R12 unknown opcode");

    repeat (2) @(negedge clk);

    // R1: reset mid-run clears a live decode
    instr_i = {7'b0100000, 5'd3, 5'd2, 3'b000, 5'd1, RR};
    rst = 1'b1;
    @(posedge clk);
    #1 check("R1 reset mid-run", actual(), '0);
    @(negedge clk) rst = 1'b0;
    w = {12'h7FF, 5'd8, 3'b110, 5'd10, OI};
    send(w, mk(w,1,0,0,1,6,0,0,0,32'h7FF,0,0,0,0,0,0,0), "R1 R4 ori after reset");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule